// File: doc/BRIEF.md
# Compressed Trap Value Register

This block holds the value that a core records when a trap is taken, sized for a core whose virtual addresses are narrower than the architectural register width. It keeps only `VASIZE+1` flops rather than `XLEN`, yet presents a full `XLEN`-bit value on its read port. The extra flop above the virtual address field lets the register tell a well-formed address (upper bits a copy of bit `VASIZE-1`) apart from a malformed one, so software reading the register can still see that a faulting address was out of range.

There are two write ports. The exception path presents the faulting effective address when a trap is taken. This is the hardware capture port. A capture checks whether the upper address bits are a proper sign extension. A well-formed address is kept exactly. A malformed one is re-encoded so that it still reads back as malformed. The instruction path performs a plain register write. This is the software port. It stores the low address bits and sign-extends them without any check. The hardware capture port has priority when both ports fire in the same cycle. A parameter option keeps all `XLEN` bits instead, and then both ports store their data verbatim.

Top module: `tval_reg`

## Requirements
- R1: A synchronous active-high reset clears the register, so `rd_value` reads zero on the cycle after the reset edge.
- R2: A hardware capture of an address whose bits `[XLEN-1:VASIZE]` all equal bit `VASIZE-1` makes `rd_value` equal that address exactly from the next cycle.
- R3: A hardware capture of an address whose bits `[XLEN-1:VASIZE]` are not all equal to bit `VASIZE-1` makes `rd_value[VASIZE-1:0]` equal the address bits `[VASIZE-1:0]`. It also makes every bit of `rd_value[XLEN-1:VASIZE]` equal the inverse of address bit `VASIZE-1`, so the value read back is still malformed.
- R4: A software write stores data bits `[VASIZE-1:0]` and makes every bit of `rd_value[XLEN-1:VASIZE]` equal data bit `VASIZE-1`, whatever the written upper bits were.
- R5: When a hardware capture and a software write occur in the same cycle, the result follows R2 or R3 for the captured address, and the software data has no effect.
- R6: In a cycle with neither write, `rd_value` keeps its value on the next cycle.
- R7: With compression enabled, bits `[XLEN-1:VASIZE]` of `rd_value` are always identical, because the stored field is sign-extended from its top bit.
- R8: With `FULL_XLEN=1`, a hardware capture or a software write stores all `XLEN` bits verbatim. A hardware capture still wins over a simultaneous software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hw_capture_en | input | 1 | Exception path writes the faulting address this cycle |
| hw_capture_addr | input | XLEN | Faulting effective address |
| sw_write_en | input | 1 | Software register write this cycle |
| sw_write_data | input | XLEN | Software write data |
| rd_value | output | XLEN | Register contents widened to XLEN bits |

## Verification
On every cycle the assertions check several properties. They check the low-field copy and the recoding of the upper bits after each kind of write, and the hardware-over-software priority. They check that the value holds when neither write port fires, and that the upper read bits stay uniform. Only the bench scenarios can show that a whole family of addresses round-trips through the recoding. These cover well-formed addresses of both signs, upper fields of all ones or all zeros against the opposite sign bit, and every single-bit corruption of the upper field. The scenarios also show that the verbatim full-width variant behaves as the same register without recoding.

// File: rtl/tval_pkg.sv
package tval_pkg;

    // Which port, if any, updates the register in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SW   = 2'd1,
        SRC_HW   = 2'd2
    } tval_src_e;

    // Hardware capture outranks software write.
    function automatic tval_src_e pick_source(input logic hw_en, input logic sw_en);
        if (hw_en)      return SRC_HW;
        else if (sw_en) return SRC_SW;
        else            return SRC_NONE;
    endfunction

endpackage

// File: rtl/tval_hw_encode.sv
module tval_hw_encode #(
    parameter int XLEN   = 64,
    parameter int VASIZE = 39
) (
    input  logic [XLEN-1:0] addr,
    output logic [VASIZE:0] enc
);
    localparam int UPW = XLEN - VASIZE;

    typedef struct packed {
        logic              ext;
        logic [VASIZE-1:0] low;
    } enc_t;

    logic    sign_bit;
    logic    upper_ok;
    enc_t    packed_val;

    always_comb begin
        sign_bit       = addr[VASIZE-1];
        upper_ok       = (addr[XLEN-1:VASIZE] == {UPW{sign_bit}});
        packed_val.low = addr[VASIZE-1:0];
        packed_val.ext = upper_ok ? sign_bit : ~sign_bit;
        enc            = packed_val;
    end
endmodule

// File: rtl/tval_sw_encode.sv
module tval_sw_encode #(
    parameter int VASIZE = 39
) (
    input  logic [VASIZE-1:0] low_data,
    output logic [VASIZE:0]   enc
);
    typedef struct packed {
        logic              ext;
        logic [VASIZE-1:0] low;
    } enc_t;

    enc_t packed_val;

    always_comb begin
        packed_val.low = low_data;
        packed_val.ext = low_data[VASIZE-1];
        enc            = packed_val;
    end
endmodule

// File: rtl/tval_store.sv
module tval_store
    import tval_pkg::*;
#(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  tval_src_e    src,
    input  logic [W-1:0] hw_val,
    input  logic [W-1:0] sw_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (src)
                SRC_HW:  q <= hw_val;
                SRC_SW:  q <= sw_val;
                default: q <= q;
            endcase
        end
    end
endmodule

// File: rtl/tval_reg.sv
module tval_reg
    import tval_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int VASIZE    = 39,
    parameter bit FULL_XLEN = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hw_capture_en,
    input  logic [XLEN-1:0] hw_capture_addr,
    input  logic            sw_write_en,
    input  logic [XLEN-1:0] sw_write_data,
    output logic [XLEN-1:0] rd_value
);
    localparam int STW = FULL_XLEN ? XLEN : VASIZE + 1;
    localparam int UPW = XLEN - VASIZE;

    tval_src_e src;
    assign src = pick_source(hw_capture_en, sw_write_en);

    generate
        if (FULL_XLEN) begin : g_full
            logic [XLEN-1:0] q;
            tval_store #(.W(XLEN)) u_store (
                .clk    (clk),
                .rst    (rst),
                .src    (src),
                .hw_val (hw_capture_addr),
                .sw_val (sw_write_data),
                .q      (q)
            );
            assign rd_value = q;
        end else begin : g_comp
            logic [STW-1:0] hw_enc;
            logic [STW-1:0] sw_enc;
            logic [STW-1:0] q;
            logic           unused_sw_upper;

            assign unused_sw_upper = ^sw_write_data[XLEN-1:VASIZE];

            tval_hw_encode #(.XLEN(XLEN), .VASIZE(VASIZE)) u_hw_enc (
                .addr (hw_capture_addr),
                .enc  (hw_enc)
            );
            tval_sw_encode #(.VASIZE(VASIZE)) u_sw_enc (
                .low_data (sw_write_data[VASIZE-1:0]),
                .enc      (sw_enc)
            );
            tval_store #(.W(STW)) u_store (
                .clk    (clk),
                .rst    (rst),
                .src    (src),
                .hw_val (hw_enc),
                .sw_val (sw_enc),
                .q      (q)
            );
            assign rd_value = {{(UPW-1){q[STW-1]}}, q};
        end
    endgenerate
endmodule

// File: rtl/tval_reg_chk.sv
module tval_reg_chk #(
    parameter int XLEN      = 64,
    parameter int VASIZE    = 39,
    parameter bit FULL_XLEN = 1'b0
) (
    input logic            clk,
    input logic            rst,
    input logic            hw_capture_en,
    input logic [XLEN-1:0] hw_capture_addr,
    input logic            sw_write_en,
    input logic [XLEN-1:0] sw_write_data,
    input logic [XLEN-1:0] rd_value
);
    localparam int UPW = XLEN - VASIZE;

    logic addr_well_formed;
    assign addr_well_formed =
        (hw_capture_addr[XLEN-1:VASIZE] == {UPW{hw_capture_addr[VASIZE-1]}});

    // R1: cleared after reset
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_value == '0));

    // R6: held when no port writes
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hw_capture_en) && !$past(sw_write_en)) |-> $stable(rd_value));

    generate
        if (FULL_XLEN) begin : g_full_chk
            // R8: verbatim capture, hardware first
            p_full_hw_r8: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(hw_capture_en)) |-> (rd_value == $past(hw_capture_addr)));
            p_full_sw_r8: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(hw_capture_en) && $past(sw_write_en))
                |-> (rd_value == $past(sw_write_data)));
        end else begin : g_comp_chk
            // R2, R5: well-formed capture exact, software data ignored
            p_hw_exact_r2: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(hw_capture_en) && $past(addr_well_formed))
                |-> (rd_value == $past(hw_capture_addr)));
            // R3, R5: malformed capture stays malformed
            p_hw_low_r3: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(hw_capture_en))
                |-> (rd_value[VASIZE-1:0] == $past(hw_capture_addr[VASIZE-1:0])));
            p_hw_bad_r3: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(hw_capture_en) && !$past(addr_well_formed))
                |-> (rd_value[XLEN-1:VASIZE] == {UPW{~rd_value[VASIZE-1]}}));
            // R4: software write sign-extends
            p_sw_ext_r4: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(hw_capture_en) && $past(sw_write_en))
                |-> (rd_value == {{UPW{$past(sw_write_data[VASIZE-1])}},
                                  $past(sw_write_data[VASIZE-1:0])}));
            // R7: upper read bits uniform
            p_upper_uniform_r7: assert property (@(posedge clk) disable iff (rst)
                (rd_value[XLEN-1:VASIZE] == '0) || (rd_value[XLEN-1:VASIZE] == '1));
        end
    endgenerate
endmodule

bind tval_reg tval_reg_chk #(
    .XLEN      (XLEN),
    .VASIZE    (VASIZE),
    .FULL_XLEN (FULL_XLEN)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .hw_capture_en   (hw_capture_en),
    .hw_capture_addr (hw_capture_addr),
    .sw_write_en     (sw_write_en),
    .sw_write_data   (sw_write_data),
    .rd_value        (rd_value)
);

// File: tb/tval_reg_tb.sv
`timescale 1ns/1ps
module tval_reg_tb;
    localparam int XLEN = 64;
    localparam int VA   = 39;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            hw_en = 1'b0;
    logic [XLEN-1:0] hw_addr = '0;
    logic            sw_en = 1'b0;
    logic [XLEN-1:0] sw_data = '0;
    logic [XLEN-1:0] rd_c;
    logic [XLEN-1:0] rd_f;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";
    string edge_req = "R1";
    logic [XLEN-1:0] exp_c = '0;
    logic [XLEN-1:0] exp_f = '0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    tval_reg #(.XLEN(XLEN), .VASIZE(VA), .FULL_XLEN(1'b0)) u_dut (
        .clk(clk), .rst(rst), .hw_capture_en(hw_en), .hw_capture_addr(hw_addr),
        .sw_write_en(sw_en), .sw_write_data(sw_data), .rd_value(rd_c));

    tval_reg #(.XLEN(XLEN), .VASIZE(VA), .FULL_XLEN(1'b1)) u_dut_full (
        .clk(clk), .rst(rst), .hw_capture_en(hw_en), .hw_capture_addr(hw_addr),
        .sw_write_en(sw_en), .sw_write_data(sw_data), .rd_value(rd_f));

    // Reference: behavioural recoding, bit by bit
    function automatic logic [XLEN-1:0] ref_hw(input logic [XLEN-1:0] a);
        logic [XLEN-1:0] r;
        bit ok = 1'b1;
        for (int i = VA; i < XLEN; i++) if (a[i] != a[VA-1]) ok = 1'b0;
        r = a;
        if (!ok) for (int i = VA; i < XLEN; i++) r[i] = ~a[VA-1];
        return r;
    endfunction

    function automatic logic [XLEN-1:0] ref_sw(input logic [XLEN-1:0] d);
        logic [XLEN-1:0] r = d;
        for (int i = VA; i < XLEN; i++) r[i] = d[VA-1];
        return r;
    endfunction

    always @(posedge clk) begin
        edge_req <= cur_req;
        started  <= 1'b1;
        if (rst) begin
            exp_c <= '0;
            exp_f <= '0;
        end else if (hw_en) begin
            exp_c <= ref_hw(hw_addr);
            exp_f <= hw_addr;
        end else if (sw_en) begin
            exp_c <= ref_sw(sw_data);
            exp_f <= sw_data;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            compared++;
            if (rd_c !== exp_c) begin
                mismatched++;
                $display("FAIL %s compressed: actual %h expected %h", edge_req, rd_c, exp_c);
            end
            compared++;
            if (rd_f !== exp_f) begin
                mismatched++;
                $display("FAIL %s full-width (R8): actual %h expected %h", edge_req, rd_f, exp_f);
            end
        end
    end

    task automatic do_hw(input logic [XLEN-1:0] a, input string req);
        @(negedge clk);
        cur_req = req; hw_en = 1'b1; hw_addr = a; sw_en = 1'b0;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic do_sw(input logic [XLEN-1:0] d, input string req);
        @(negedge clk);
        cur_req = req; sw_en = 1'b1; sw_data = d; hw_en = 1'b0;
        @(negedge clk);
        sw_en = 1'b0;
    endtask

    task automatic do_both(input logic [XLEN-1:0] a, input logic [XLEN-1:0] d);
        @(negedge clk);
        cur_req = "R5"; hw_en = 1'b1; hw_addr = a; sw_en = 1'b1; sw_data = d;
        @(negedge clk);
        hw_en = 1'b0; sw_en = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cur_req = "R6";
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        mismatched++;
        $display("FAIL watchdog expired before the run completed");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [XLEN-1:0] base;
        repeat (3) @(negedge clk);
        rst = 1'b0;                          // R1 checked on following compares
        idle(2);
        // R2: well-formed, both signs
        do_hw(64'h0000_0012_3456_789A, "R2");
        do_hw(64'hFFFF_FFC0_0000_0010, "R2");
        do_hw(64'h0000_003F_FFFF_FFFF, "R2");
        do_hw(64'hFFFF_FFC0_0000_0000, "R2");
        idle(3);                              // R6
        // R3: upper all ones with positive field, all zeros with negative field
        do_hw(64'hFFFF_FF80_0000_1234, "R3");
        do_hw(64'h0000_0040_0000_5678, "R3");
        idle(2);
        // R3: every single-bit corruption of the upper field, both signs
        for (int b = VA; b < XLEN; b++) begin
            base = 64'h0000_0001_2345_6700;
            base[b] = 1'b1;
            do_hw(base, "R3");
            base = 64'hFFFF_FFC0_ABCD_0001;
            base[b] = 1'b0;
            do_hw(base, "R3");
        end
        // R4, R7: software write ignores upper bits
        do_sw(64'hA5A5_A500_1111_2222, "R4");
        do_sw(64'h0000_0040_0000_0001, "R4");
        do_sw(64'h1234_5612_3456_789A, "R7");
        idle(2);
        // R5: hardware wins
        do_both(64'h0000_0000_0000_0ABC, 64'hFFFF_FFFF_FFFF_FFFF);
        do_both(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001);
        // R8: mixed patterns on both instances
        for (int k = 0; k < 16; k++) begin
            base = {$urandom, $urandom};
            if (k[0]) do_hw(base, "R8"); else do_sw(base, "R8");
        end
        // R1: reset in the middle of a run
        @(negedge clk);
        cur_req = "R1"; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule